// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of an SDRAM device from reset until the device is usable. After reset it keeps the command bus deselected for a programmable number of cycles, with the clock enable and the data mask held high. It then precharges every bank and runs a fixed batch of auto-refresh commands at the row-cycle spacing. It finishes by loading a mode word chosen at build time into the mode register, and then signals that initialisation is complete.

Once initialised, the block counts refresh intervals and keeps a tally of refreshes that are owed. The tally saturates at a parameter value. While the tally is non-zero and the bus is idle, the block asks the main controller for the bus. When the request is granted, it precharges all banks, waits the precharge time, issues one auto-refresh, waits the row-cycle time and hands the bus back. The tally lets a refresh wait for a busy controller without being dropped, up to the saturation depth. All waits are whole-cycle counts set by parameters.

Top module: `sdram_init_refresh`

## Requirements
- R1: While in reset and for exactly PWRUP_CYC cycles after reset is released, the command bus is deselected (chip select high). During the whole of initialisation the clock enable and the data mask are driven high.
- R2: The first command after the power-up wait is precharge-all: chip select 0, row strobe 0, column strobe 1, write enable 0, with address bit 10 set to 1.
- R3: Exactly INIT_REFS auto-refresh commands (chip select 0, row strobe 0, column strobe 0, write enable 1) follow. The first comes T_RP cycles after the precharge-all, and each later one comes T_RC cycles after the one before it.
- R4: The mode register write (chip select, row strobe, column strobe and write enable all 0) comes T_RC cycles after the last initial refresh. It carries MODE_ADDR on the address pins and MODE_BA on the bank pins.
- R5: initDone rises T_MRD cycles after the mode register write appears on the pins, and the data mask drops at that point. refReq stays low until initDone is high.
- R6: After initDone, one refresh becomes owed every REF_INTERVAL cycles. Whenever busFree is high, refReq is high if and only if at least one refresh is owed.
- R7: A precharge-all appears on the pins in the cycle after a clock edge at which both refReq and refGnt were high, and at no other time after initialisation. A grant given while refReq is low has no effect.
- R8: After that precharge-all, an auto-refresh follows T_RP cycles later, and busFree rises again T_RC cycles after the refresh. While busFree is high the pins carry NOP (chip select 0, the three strobes 1), and no mode register write is issued after initialisation.
- R9: The owed tally saturates at OWED_MAX; each later interval that expires while the tally is full is dropped. A refresh is never issued when none is owed, and no owed refresh is lost below saturation.
- R10: Every command occupies the pins for exactly one cycle and is followed by at least one NOP cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| refGnt | input | 1 | Main controller hands the bus over for one refresh |
| refReq | output | 1 | A refresh is owed and the sequencer wants the bus |
| busFree | output | 1 | The sequencer is idle after initialisation; the controller may use the bus |
| initDone | output | 1 | Initialisation is complete |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 1 | SDRAM chip select, active low |
| sdRasN | output | 1 | SDRAM row strobe, active low |
| sdCasN | output | 1 | SDRAM column strobe, active low |
| sdWeN | output | 1 | SDRAM write enable, active low |
| sdDqm | output | 1 | SDRAM data mask |
| sdAddr | output | ADDR_W | SDRAM address pins |
| sdBa | output | BANK_W | SDRAM bank select pins |

## Verification
The bench measures the exact cycle spacing between commands. A wait counter that is off by one moves the first precharge, a refresh or the mode write away from its expected cycle, and a miscounted initial batch gives the wrong number of refreshes before the mode write. Random grants, some of them given with no request pending, expose a sequencer that reacts to a stray grant or that fails to precharge in the cycle after a real one. A long stretch with the grant withheld drives the owed tally into saturation, and the drain that follows is compared cycle by cycle with an independent tally in the bench. A design that wraps instead of saturating, drops refreshes below the limit, or refreshes with nothing owed then shows refReq out of step with that tally.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_INIT_RP,
    ST_INIT_RC,
    ST_INIT_MRD,
    ST_IDLE,
    ST_RUN_RP,
    ST_RUN_RC
  } seqState_t;

  // strobes from control to datapath; each issue strobe also reloads the wait timer
  typedef struct packed {
    logic issuePall;
    logic issueRef;
    logic issueMrs;
    logic setDone;
  } seqStrobe_t;

  // {rasN, casN, weN} encodings with chip select low
  localparam logic [2:0] CMD_NOP  = 3'b111;
  localparam logic [2:0] CMD_PALL = 3'b010;
  localparam logic [2:0] CMD_REF  = 3'b001;
  localparam logic [2:0] CMD_MRS  = 3'b000;

endpackage

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       timerZero,
  input  logic       initRefsDone,
  input  logic       owedNZ,
  input  logic       initDone,
  input  logic       refGnt,
  output seqStrobe_t strb,
  output logic       refReq,
  output logic       busFree
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PWRUP;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_PWRUP: if (timerZero) begin
        strb.issuePall = 1'b1;
        stateNext      = ST_INIT_RP;
      end
      ST_INIT_RP: if (timerZero) begin
        strb.issueRef = 1'b1;
        stateNext     = ST_INIT_RC;
      end
      ST_INIT_RC: if (timerZero) begin
        if (initRefsDone) begin
          strb.issueMrs = 1'b1;
          stateNext     = ST_INIT_MRD;
        end else begin
          strb.issueRef = 1'b1;
        end
      end
      ST_INIT_MRD: if (timerZero) begin
        strb.setDone = 1'b1;
        stateNext    = ST_IDLE;
      end
      ST_IDLE: if (owedNZ && refGnt) begin
        strb.issuePall = 1'b1;
        stateNext      = ST_RUN_RP;
      end
      ST_RUN_RP: if (timerZero) begin
        strb.issueRef = 1'b1;
        stateNext     = ST_RUN_RC;
      end
      ST_RUN_RC: if (timerZero) stateNext = ST_IDLE;
      default: stateNext = ST_PWRUP;
    endcase
  end

  assign busFree = (state == ST_IDLE);
  assign refReq  = (state == ST_IDLE) && owedNZ;

  AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> initDone);  // R5

  AST_GRANT_TAKES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGnt) |=> !busFree);  // R7

  AST_REF_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issueRef && initDone) |-> owedNZ);  // R9

endmodule

// File: rtl/sdr_seq_dp.sv
module sdr_seq_dp
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int BANK_W       = 2,
  parameter int PWRUP_CYC    = 20000000,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_MRD        = 2,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 78,
  parameter int OWED_MAX     = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h020,
  parameter logic [BANK_W-1:0] MODE_BA   = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  output logic              timerZero,
  output logic              initRefsDone,
  output logic              owedNZ,
  output logic              initDone,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdDqm,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0] sdBa
);

  localparam int GAP_A   = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int GAP_B   = (GAP_A > T_MRD) ? GAP_A : T_MRD;
  localparam int MAXWAIT = (PWRUP_CYC > GAP_B) ? PWRUP_CYC : GAP_B;
  localparam int TW      = $clog2(MAXWAIT + 1);
  localparam int CW      = $clog2(INIT_REFS + 1);
  localparam int IW      = $clog2(REF_INTERVAL);
  localparam int OW      = $clog2(OWED_MAX + 1);

  // wait timer: an issue strobe loads (gap - 1), so the next issue lands gap cycles later
  logic [TW-1:0] timer;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               timer <= TW'(PWRUP_CYC - 1);
    else if (strb.issuePall) timer <= TW'(T_RP - 1);
    else if (strb.issueRef)  timer <= TW'(T_RC - 1);
    else if (strb.issueMrs)  timer <= TW'(T_MRD - 1);
    else if (timer != '0)    timer <= timer - 1'b1;
  end
  assign timerZero = (timer == '0);

  // initial refresh batch
  logic [CW-1:0] initRefsLeft;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initRefsLeft <= CW'(INIT_REFS);
    else if (strb.issueRef && !initDone && initRefsLeft != '0)
      initRefsLeft <= initRefsLeft - 1'b1;
  end
  assign initRefsDone = (initRefsLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             initDone <= 1'b0;
    else if (strb.setDone) initDone <= 1'b1;
  end

  // refresh interval and owed tally
  logic [IW-1:0] ivCnt;
  logic          tick, dec;
  logic [OW-1:0] owed;

  assign tick = initDone && (ivCnt == IW'(REF_INTERVAL - 1));
  assign dec  = strb.issueRef && initDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             ivCnt <= '0;
    else if (!initDone)                    ivCnt <= '0;
    else if (ivCnt == IW'(REF_INTERVAL-1)) ivCnt <= '0;
    else                                   ivCnt <= ivCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owed <= '0;
    else begin
      unique case ({tick, dec})
        2'b10: if (owed != OW'(OWED_MAX)) owed <= owed + 1'b1;
        2'b01: owed <= owed - 1'b1;
        default: ;
      endcase
    end
  end
  assign owedNZ = (owed != '0);

  // command pins
  logic              awake;
  logic [2:0]        cmdNext, cmdQ;
  logic [ADDR_W-1:0] addrNext;
  logic [BANK_W-1:0] baNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                awake <= 1'b0;
    else if (strb.issuePall)  awake <= 1'b1;
  end

  always_comb begin
    cmdNext  = CMD_NOP;
    addrNext = '0;
    baNext   = '0;
    if (strb.issuePall) begin
      cmdNext      = CMD_PALL;
      addrNext[10] = 1'b1;
    end else if (strb.issueRef) begin
      cmdNext = CMD_REF;
    end else if (strb.issueMrs) begin
      cmdNext  = CMD_MRS;
      addrNext = MODE_ADDR;
      baNext   = MODE_BA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdCsN  <= 1'b1;
      cmdQ   <= CMD_NOP;
      sdAddr <= '0;
      sdBa   <= '0;
    end else begin
      sdCsN  <= !(awake || strb.issuePall);
      cmdQ   <= cmdNext;
      sdAddr <= addrNext;
      sdBa   <= baNext;
    end
  end

  assign {sdRasN, sdCasN, sdWeN} = cmdQ;
  assign sdCke = 1'b1;
  assign sdDqm = !initDone;

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    owed <= OW'(OWED_MAX));  // R9

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!sdCsN && cmdQ != CMD_NOP) |=> (cmdQ == CMD_NOP));  // R10

endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int BANK_W       = 2,
  parameter int PWRUP_CYC    = 20000000,
  parameter int T_RP         = 2,
  parameter int T_RC         = 7,
  parameter int T_MRD        = 2,
  parameter int INIT_REFS    = 8,
  parameter int REF_INTERVAL = 78,
  parameter int OWED_MAX     = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h020,
  parameter logic [BANK_W-1:0] MODE_BA   = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refGnt,
  output logic              refReq,
  output logic              busFree,
  output logic              initDone,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic              sdDqm,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0] sdBa
);

  seqStrobe_t strb;
  logic timerZero, initRefsDone, owedNZ;

  sdr_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .timerZero    (timerZero),
    .initRefsDone (initRefsDone),
    .owedNZ       (owedNZ),
    .initDone     (initDone),
    .refGnt       (refGnt),
    .strb         (strb),
    .refReq       (refReq),
    .busFree      (busFree)
  );

  sdr_seq_dp #(
    .ADDR_W       (ADDR_W),
    .BANK_W       (BANK_W),
    .PWRUP_CYC    (PWRUP_CYC),
    .T_RP         (T_RP),
    .T_RC         (T_RC),
    .T_MRD        (T_MRD),
    .INIT_REFS    (INIT_REFS),
    .REF_INTERVAL (REF_INTERVAL),
    .OWED_MAX     (OWED_MAX),
    .MODE_ADDR    (MODE_ADDR),
    .MODE_BA      (MODE_BA)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .timerZero    (timerZero),
    .initRefsDone (initRefsDone),
    .owedNZ       (owedNZ),
    .initDone     (initDone),
    .sdCke        (sdCke),
    .sdCsN        (sdCsN),
    .sdRasN       (sdRasN),
    .sdCasN       (sdCasN),
    .sdWeN        (sdWeN),
    .sdDqm        (sdDqm),
    .sdAddr       (sdAddr),
    .sdBa         (sdBa)
  );

endmodule

// File: tb/sim_sdram_init_refresh.sv
`timescale 1ns/1ps
module sim_sdram_init_refresh;

  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int PWRUP  = 50;
  localparam int RP     = 2;
  localparam int RC     = 7;
  localparam int MRD    = 2;
  localparam int NREF   = 8;
  localparam int RI     = 40;
  localparam int OMAX   = 8;
  localparam logic [ADDR_W-1:0] MADDR = 13'h032;
  localparam logic [BANK_W-1:0] MBA   = 2'b01;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, refGnt;
  logic refReq, busFree, initDone, sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdDqm;
  logic [ADDR_W-1:0] sdAddr;
  logic [BANK_W-1:0] sdBa;

  sdram_init_refresh #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PWRUP_CYC(PWRUP), .T_RP(RP), .T_RC(RC),
    .T_MRD(MRD), .INIT_REFS(NREF), .REF_INTERVAL(RI), .OWED_MAX(OMAX),
    .MODE_ADDR(MADDR), .MODE_BA(MBA)
  ) u0 (
    .clk(clk), .rstN(rstN), .refGnt(refGnt), .refReq(refReq), .busFree(busFree),
    .initDone(initDone), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdDqm(sdDqm), .sdAddr(sdAddr), .sdBa(sdBa)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit cmdIs(input logic [2:0] code);
    return !sdCsN && ({sdRasN, sdCasN, sdWeN} == code);
  endfunction

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // monitor state
  int phase = 0;
  int lastPall = 0, lastRef = 0, mrsCyc = 0, refCnt = 0;
  int sinceDone = 0, owedM = 0, lost = 0;
  bit seenDone = 0, prevReq = 0, prevBusFree = 0, lastWasCmd = 0;

  always @(negedge clk) begin
    if (rstN) begin
      bit isPall, isRef, isMrs, isCmd, tick;
      isPall = cmdIs(3'b010);
      isRef  = cmdIs(3'b001);
      isMrs  = cmdIs(3'b000);
      isCmd  = !sdCsN && ({sdRasN, sdCasN, sdWeN} != 3'b111);

      if (lastWasCmd) chk(!isCmd, "R10", "command held longer than one cycle", int'(isCmd), 0);
      lastWasCmd = isCmd;

      if (!initDone) begin
        chk(sdDqm && sdCke, "R1", "dqm/cke high during init", int'({sdDqm, sdCke}), 3);
        chk(!refReq, "R5", "request before init done", int'(refReq), 0);
      end

      if (phase == 0) begin
        if (!sdCsN) begin
          chk(cyc == PWRUP, "R1", "first command cycle", cyc, PWRUP);
          chk(isPall && sdAddr[10], "R2", "first command precharge-all with A10",
              int'({sdRasN, sdCasN, sdWeN, sdAddr[10]}), 4'b0101);
          phase = 1;
          lastPall = cyc;
        end
      end else if (!initDone) begin
        chk(!sdCsN, "R1", "chip select low after wake-up", int'(sdCsN), 0);
        if (isRef) begin
          if (refCnt == 0) chk(cyc - lastPall == RP, "R3", "first refresh gap", cyc - lastPall, RP);
          else             chk(cyc - lastRef == RC, "R3", "refresh spacing", cyc - lastRef, RC);
          refCnt++;
          lastRef = cyc;
        end else if (isMrs) begin
          chk(refCnt == NREF, "R3", "initial refresh count", refCnt, NREF);
          chk(cyc - lastRef == RC, "R4", "mode write gap", cyc - lastRef, RC);
          chk(sdAddr == MADDR, "R4", "mode address", int'(sdAddr), int'(MADDR));
          chk(sdBa == MBA, "R4", "mode bank", int'(sdBa), int'(MBA));
          mrsCyc = cyc;
        end else if (isPall) begin
          chk(0, "R2", "second precharge-all during init", 1, 0);
        end
      end else begin
        if (!seenDone) begin
          seenDone = 1;
          chk(cyc - mrsCyc == MRD, "R5", "init done delay", cyc - mrsCyc, MRD);
          chk(!sdDqm, "R5", "dqm released", int'(sdDqm), 0);
          sinceDone = 0;
        end else begin
          sinceDone++;
          if (busFree && !prevBusFree)
            chk(cyc - lastRef == RC, "R8", "bus release after refresh", cyc - lastRef, RC);
        end
        tick = (sinceDone > 0) && (sinceDone % RI == 0);

        // grant at the last edge counts only when a request was pending
        chk(isPall == (prevReq && refGnt), "R7", "precharge-all versus grant",
            int'(isPall), int'(prevReq && refGnt));
        if (isPall) lastPall = cyc;
        if (isRef) begin
          chk(cyc - lastPall == RP, "R8", "refresh after precharge-all", cyc - lastPall, RP);
          chk(owedM > 0, "R9", "refresh with nothing owed", owedM, 1);
          lastRef = cyc;
        end
        if (isMrs) chk(0, "R8", "mode write after init", 1, 0);
        if (busFree)
          chk(!sdCsN && {sdRasN, sdCasN, sdWeN} == 3'b111, "R8", "NOP while bus free",
              int'({sdCsN, sdRasN, sdCasN, sdWeN}), 4'b0111);

        // independent owed tally
        if (tick && !isRef) begin
          if (owedM < OMAX) owedM++;
          else              lost++;
        end else if (!tick && isRef && owedM > 0) begin
          owedM--;
        end

        if (busFree)
          chk(refReq == (owedM > 0), "R6", "request versus owed tally", int'(refReq), int'(owedM > 0));
        prevBusFree = busFree;
      end
      prevReq = refReq;
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN   = 1'b0;
    refGnt = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(sdCsN && sdCke && sdDqm && !initDone && !refReq && !busFree, "R1", "reset state",
        int'({sdCsN, sdCke, sdDqm, initDone, refReq, busFree}), 6'b111000);
    rstN = 1'b1;

    for (int i = 0; i < 2000 && !initDone; i++) @(negedge clk);
    chk(initDone, "R5", "init completes", int'(initDone), 1);

    // random grants, including grants with no request pending
    repeat (60 * RI) begin
      @(negedge clk);
      #1;
      if (refReq) refGnt = ($urandom % 3) == 0;
      else        refGnt = ($urandom % 4) == 0;
    end

    // starve: tally must saturate
    @(negedge clk); #1;
    refGnt = 1'b0;
    repeat (12 * RI) @(negedge clk);
    #1;
    chk(lost > 0, "R9", "saturation reached while starved", lost, 1);
    chk(refReq && owedM == OMAX, "R9", "tally full while starved", owedM, OMAX);

    // drain with grant held high
    refGnt = 1'b1;
    repeat (20 * RI) @(negedge clk);
    #1;
    chk(owedM <= 1, "R9", "tally drained", owedM, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule